// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This engine rewrites every byte of a nonvolatile data array in place so that stored charge is restored without software having to run a refresh loop. On a start pulse it walks the whole address space. For each location it reads the current byte and writes that same byte back through the guarded write controller. It drives the controller's byte-wide register interface exactly as a processor would: it loads the address registers, issues a read, performs the two-key unlock, starts the write and polls for completion.

The address is kept as a low byte and a high part. The low byte steps after each completed write, the high part steps when the low byte wraps, and the run ends once the high part wraps as well. For the whole run the engine raises a request that masks processor interrupts, and its busy output lets the system lock the processor out of the controller. A write error reported by the controller stops the run and leaves the failing address for inspection.

Top module: `nvm_refresh_seq`

## Requirements
- R1: After reset busy_o, done_o, err_o and irq_mask_o are low, and the register bus issues no read or write while the engine is idle.
- R2: A start_i pulse seen while idle makes busy_o and irq_mask_o high on the next cycle, and irq_mask_o stays high for as long as busy_o does.
- R3: The first register access of a run writes the control register (select 3) with 8'h04: write enable (bit 2) set, the program-memory select (bit 7) and configuration select (bit 6) clear. The first address written is low byte 0 and high part 0.
- R4: For each address the engine writes the low address register (select 0), writes the high address register (select 1), writes control 8'h05 (read strobe bit 0), reads the data register (select 2), writes that byte back to the data register, writes 8'h55 and then 8'hAA to the key register (select 4), and then writes control 8'h06 (write start bit 1), with nothing in between.
- R5: After starting a write the engine only reads the control register, and it makes no register write while control bit 1 reads high.
- R6: The low address byte steps after each completed write. When it wraps to zero the high part steps. Every address from 0 to 2^(LO_W+HI_W)-1 is written exactly once, in ascending order.
- R7: At the end of a run the engine writes control 8'h00. After that busy_o and irq_mask_o fall together, and done_o is high for exactly the first idle cycle.
- R8: start_i pulses received while busy_o is high have no effect on the run.
- R9: If a poll reads control bit 3 (write error) high, the engine makes no further write attempt. It writes control 8'h00, raises err_o, presents the failing address on err_addr_o as {high, low}, and ends with a done_o pulse.
- R10: err_o and err_addr_o hold until the next accepted start, which clears them.
- R11: The byte written back at each address equals the byte read there, so the array contents are unchanged by a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, ignored while busy |
| busy_o | output | 1 | Refresh run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| err_o | output | 1 | Last run stopped on a write error |
| err_addr_o | output | LO_W+HI_W | Address of the failed write, {high, low} |
| irq_mask_o | output | 1 | Request to mask processor interrupts |
| reg_wr_o | output | 1 | Register write strobe to the write controller |
| reg_rd_o | output | 1 | Register read strobe to the write controller |
| reg_sel_o | output | 3 | Register select: 0 addr low, 1 addr high, 2 data, 3 control, 4 key |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the cycle of the read strobe |

## Verification
The bench pairs the engine with a behavioural write controller. The controller refuses a write start that is not immediately preceded by the two keys. Such a design would leave locations unwritten and show a write count short of the array size. The controller's write time is random, which exposes an engine that advances before the busy bit clears or writes while it is set. Carry from the low byte into the high part is checked by requiring strictly ascending write addresses across the whole array, since a broken carry repeats or skips a block of 256. Write errors are injected at the first, a random and the last address; an engine that mis-latched the address or kept going would report the wrong location or an extra write. Start pulses are also scattered through one run, where a design that restarted would rewrite low addresses twice.

// File: rtl/nvm_refresh_pkg.sv
package nvm_refresh_pkg;

    localparam int REG_W = 8;

    // register selects on the controller bus
    typedef enum logic [2:0] {
        SEL_ADR_LO = 3'd0,
        SEL_ADR_HI = 3'd1,
        SEL_DATA   = 3'd2,
        SEL_CTRL   = 3'd3,
        SEL_KEY    = 3'd4
    } reg_sel_e;

    // control register bit positions
    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_WEN = 2;
    localparam int CB_ERR = 3;
    localparam int CB_CFG = 6;
    localparam int CB_PGM = 7;

    localparam logic [REG_W-1:0] UNLOCK_FIRST  = 8'h55;
    localparam logic [REG_W-1:0] UNLOCK_SECOND = 8'hAA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADRL,
        ST_ADRH,
        ST_RDCMD,
        ST_FETCH,
        ST_DATA,
        ST_KEY1,
        ST_KEY2,
        ST_GO,
        ST_POLL,
        ST_CLOSE
    } seq_state_e;

    // control word with array selects cleared (data array)
    function automatic logic [REG_W-1:0] ctrl_word(input logic rd, input logic wr, input logic wen);
        logic [REG_W-1:0] w;
        w         = '0;
        w[CB_RD]  = rd;
        w[CB_WR]  = wr;
        w[CB_WEN] = wen;
        w[CB_CFG] = 1'b0;
        w[CB_PGM] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/nvm_refresh_addr.sv
module nvm_refresh_addr
    import nvm_refresh_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            step_i,
    output logic [LO_W-1:0] lo_o,
    output logic [HI_W-1:0] hi_o,
    output logic            last_o
);

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } addr_t;

    addr_t addr_d, addr_q;
    logic  lo_wrap;

    always_comb begin
        addr_d  = addr_q;
        lo_wrap = &addr_q.lo;
        if (clr_i) begin
            addr_d = '0;
        end else if (step_i) begin
            addr_d.lo = addr_q.lo + 1'b1;
            if (lo_wrap) begin
                addr_d.hi = addr_q.hi + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign lo_o   = addr_q.lo;
    assign hi_o   = addr_q.hi;
    // stepping from here would wrap the high part as well
    assign last_o = (&addr_q.lo) & (&addr_q.hi);

endmodule

// File: rtl/nvm_refresh_bus.sv
module nvm_refresh_bus
    import nvm_refresh_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 2
) (
    input  seq_state_e       state_i,
    input  logic [LO_W-1:0]  lo_i,
    input  logic [HI_W-1:0]  hi_i,
    input  logic [REG_W-1:0] data_i,
    output logic             wr_o,
    output logic             rd_o,
    output reg_sel_e         sel_o,
    output logic [REG_W-1:0] wdata_o
);

    always_comb begin
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        sel_o   = SEL_CTRL;
        wdata_o = '0;
        unique case (state_i)
            ST_SETUP: begin
                wr_o    = 1'b1;
                sel_o   = SEL_CTRL;
                wdata_o = ctrl_word(1'b0, 1'b0, 1'b1);
            end
            ST_ADRL: begin
                wr_o    = 1'b1;
                sel_o   = SEL_ADR_LO;
                wdata_o = REG_W'(lo_i);
            end
            ST_ADRH: begin
                wr_o    = 1'b1;
                sel_o   = SEL_ADR_HI;
                wdata_o = REG_W'(hi_i);
            end
            ST_RDCMD: begin
                wr_o    = 1'b1;
                sel_o   = SEL_CTRL;
                wdata_o = ctrl_word(1'b1, 1'b0, 1'b1);
            end
            ST_FETCH: begin
                rd_o  = 1'b1;
                sel_o = SEL_DATA;
            end
            ST_DATA: begin
                wr_o    = 1'b1;
                sel_o   = SEL_DATA;
                wdata_o = data_i;
            end
            ST_KEY1: begin
                wr_o    = 1'b1;
                sel_o   = SEL_KEY;
                wdata_o = UNLOCK_FIRST;
            end
            ST_KEY2: begin
                wr_o    = 1'b1;
                sel_o   = SEL_KEY;
                wdata_o = UNLOCK_SECOND;
            end
            ST_GO: begin
                wr_o    = 1'b1;
                sel_o   = SEL_CTRL;
                wdata_o = ctrl_word(1'b0, 1'b1, 1'b1);
            end
            ST_POLL: begin
                rd_o  = 1'b1;
                sel_o = SEL_CTRL;
            end
            ST_CLOSE: begin
                wr_o    = 1'b1;
                sel_o   = SEL_CTRL;
                wdata_o = ctrl_word(1'b0, 1'b0, 1'b0);
            end
            default: begin
                wr_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nvm_refresh_seq.sv
module nvm_refresh_seq
    import nvm_refresh_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [LO_W+HI_W-1:0] err_addr_o,
    output logic                 irq_mask_o,
    output logic                 reg_wr_o,
    output logic                 reg_rd_o,
    output logic [2:0]           reg_sel_o,
    output logic [7:0]           reg_wdata_o,
    input  logic [7:0]           reg_rdata_i
);

    localparam int ADDR_W = LO_W + HI_W;

    typedef struct packed {
        seq_state_e       st;
        logic [REG_W-1:0] data;
        logic             mask;
        logic             done;
        logic             err;
        logic [ADDR_W-1:0] err_addr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            addr_clr;
    logic            addr_step;
    logic [LO_W-1:0] addr_lo;
    logic [HI_W-1:0] addr_hi;
    logic            addr_last;
    reg_sel_e        bus_sel;

    nvm_refresh_addr #(
        .LO_W (LO_W),
        .HI_W (HI_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (addr_clr),
        .step_i (addr_step),
        .lo_o   (addr_lo),
        .hi_o   (addr_hi),
        .last_o (addr_last)
    );

    nvm_refresh_bus #(
        .LO_W (LO_W),
        .HI_W (HI_W)
    ) u_bus (
        .state_i (seq_q.st),
        .lo_i    (addr_lo),
        .hi_i    (addr_hi),
        .data_i  (seq_q.data),
        .wr_o    (reg_wr_o),
        .rd_o    (reg_rd_o),
        .sel_o   (bus_sel),
        .wdata_o (reg_wdata_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        addr_clr   = 1'b0;
        addr_step  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st       = ST_SETUP;
                    seq_d.mask     = 1'b1;
                    seq_d.err      = 1'b0;
                    seq_d.err_addr = '0;
                    addr_clr       = 1'b1;
                end
            end
            ST_SETUP: seq_d.st = ST_ADRL;
            ST_ADRL:  seq_d.st = ST_ADRH;
            ST_ADRH:  seq_d.st = ST_RDCMD;
            ST_RDCMD: seq_d.st = ST_FETCH;
            ST_FETCH: begin
                seq_d.data = reg_rdata_i;
                seq_d.st   = ST_DATA;
            end
            ST_DATA:  seq_d.st = ST_KEY1;
            ST_KEY1:  seq_d.st = ST_KEY2;
            ST_KEY2:  seq_d.st = ST_GO;
            ST_GO:    seq_d.st = ST_POLL;
            ST_POLL: begin
                if (reg_rdata_i[CB_ERR]) begin
                    seq_d.err      = 1'b1;
                    seq_d.err_addr = {addr_hi, addr_lo};
                    seq_d.st       = ST_CLOSE;
                end else if (!reg_rdata_i[CB_WR]) begin
                    if (addr_last) begin
                        seq_d.st = ST_CLOSE;
                    end else begin
                        addr_step = 1'b1;
                        seq_d.st  = ST_ADRL;
                    end
                end
            end
            ST_CLOSE: begin
                seq_d.st   = ST_IDLE;
                seq_d.mask = 1'b0;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o     = (seq_q.st != ST_IDLE);
    assign done_o     = seq_q.done;
    assign err_o      = seq_q.err;
    assign err_addr_o = seq_q.err_addr;
    assign irq_mask_o = seq_q.mask;
    assign reg_sel_o  = bus_sel;

endmodule

// File: rtl/nvm_refresh_chk.sv
module nvm_refresh_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       irq_mask_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o,
    input logic [2:0] reg_sel_o,
    input logic [7:0] reg_wdata_o,
    input logic [7:0] reg_rdata_i
);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(reg_wr_o || reg_rd_o));

    p_mask_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> irq_mask_o);

    p_mask_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !irq_mask_o);

    p_go_after_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && reg_sel_o == 3'd3 && reg_wdata_o[1])
        |-> $past(reg_wr_o && reg_sel_o == 3'd4 && reg_wdata_o == 8'hAA));

    p_poll_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_o && reg_sel_o == 3'd3 && reg_rdata_i[1] && !reg_rdata_i[3])
        |=> !reg_wr_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_rise_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind nvm_refresh_seq nvm_refresh_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_mask_o  (irq_mask_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_sel_o   (reg_sel_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
);

// File: tb/nvm_refresh_seq_bench.sv
module nvm_refresh_seq_bench;

    localparam int LO_W  = 8;
    localparam int HI_W  = 2;
    localparam int AW    = LO_W + HI_W;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, err, mask;
    logic [AW-1:0] err_addr;
    logic          reg_wr, reg_rd;
    logic [2:0]    reg_sel;
    logic [7:0]    reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nvm_refresh_seq #(.LO_W(LO_W), .HI_W(HI_W)) u_nvm_refresh_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .err_addr_o  (err_addr),
        .irq_mask_o  (mask),
        .reg_wr_o    (reg_wr),
        .reg_rd_o    (reg_rd),
        .reg_sel_o   (reg_sel),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    // array contents as loaded at reset
    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37 + 90) ^ (a >> 3));
    endfunction

    // ---------------- behavioural write controller ----------------
    logic [7:0]    mem [DEPTH];
    logic [7:0]    adrl, adrh, datar, ctrl;
    int            key_st;
    int            wcnt;
    logic [AW-1:0] wadr;
    logic [AW-1:0] cur;
    int            writes, exp_next;
    int            viol_key, viol_poll, viol_order, viol_data;
    logic [7:0]    first_ctrl, last_ctrl, first_lo, first_hi;
    bit            first_ctrl_pend, first_adr_pend;
    bit            fail_en = 1'b0;
    int            fail_at = 0;

    assign cur = {adrh[HI_W-1:0], adrl[LO_W-1:0]};
    assign reg_rdata = (reg_sel == 3'd0) ? adrl :
                       (reg_sel == 3'd1) ? adrh :
                       (reg_sel == 3'd2) ? datar :
                       (reg_sel == 3'd3) ? ctrl : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
            adrl <= 0; adrh <= 0; datar <= 0; ctrl <= 0; key_st <= 0; wcnt <= 0; wadr <= 0;
            writes <= 0; exp_next <= 0;
            viol_key <= 0; viol_poll <= 0; viol_order <= 0; viol_data <= 0;
            first_ctrl <= 8'hFF; last_ctrl <= 8'hFF; first_lo <= 8'hFF; first_hi <= 8'hFF;
            first_ctrl_pend <= 0; first_adr_pend <= 0;
        end else begin
            if (start && !busy) begin
                exp_next <= 0;
                first_ctrl_pend <= 1;
                first_adr_pend <= 1;
            end
            if (wcnt != 0) begin
                if (wcnt == 1) begin
                    mem[wadr] <= datar;
                    ctrl[1] <= 1'b0;
                    if (datar != init_byte(int'(wadr))) viol_data <= viol_data + 1;
                    if (int'(wadr) != exp_next) viol_order <= viol_order + 1;
                    exp_next <= exp_next + 1;
                    writes <= writes + 1;
                end
                wcnt <= wcnt - 1;
            end
            if (reg_wr) begin
                if (ctrl[1]) viol_poll <= viol_poll + 1;
                case (reg_sel)
                    3'd0: begin
                        adrl <= reg_wdata; key_st <= 0;
                        if (first_adr_pend) first_lo <= reg_wdata;
                    end
                    3'd1: begin
                        adrh <= reg_wdata; key_st <= 0;
                        if (first_adr_pend) begin first_hi <= reg_wdata; first_adr_pend <= 0; end
                    end
                    3'd2: begin
                        datar <= reg_wdata; key_st <= 0;
                        if (reg_wdata != mem[cur]) viol_data <= viol_data + 1;
                    end
                    3'd4: begin
                        if (reg_wdata == 8'h55) key_st <= 1;
                        else if (reg_wdata == 8'hAA && key_st == 1) key_st <= 2;
                        else key_st <= 0;
                    end
                    3'd3: begin
                        key_st <= 0;
                        last_ctrl <= reg_wdata;
                        if (first_ctrl_pend) begin first_ctrl <= reg_wdata; first_ctrl_pend <= 0; end
                        ctrl <= reg_wdata & 8'hF4;
                        if (reg_wdata[0]) datar <= mem[cur];
                        if (reg_wdata[1]) begin
                            if (key_st != 2 || !reg_wdata[2] || reg_wdata[7:6] != 2'b00) begin
                                viol_key <= viol_key + 1;
                            end else if (fail_en && int'(cur) == fail_at) begin
                                ctrl <= (reg_wdata & 8'hF4) | 8'h08;
                            end else begin
                                ctrl <= (reg_wdata & 8'hF4) | 8'h02;
                                wcnt <= int'($urandom_range(1, 5));
                                wadr <= cur;
                            end
                        end
                    end
                    default: key_st <= 0;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_writes(input bit inj, input int fa);
        return inj ? fa : DEPTH;
    endfunction

    task automatic mem_unchanged(input string req);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != init_byte(i)) bad++;
        chk(bad == 0, req, "array bytes changed", bad, 0);
    endtask

    task automatic do_run(input bit inj, input int fa, input bit extra);
        int w0, vk0, vp0, vo0, vd0;
        w0 = writes; vk0 = viol_key; vp0 = viol_poll; vo0 = viol_order; vd0 = viol_data;
        fail_en = inj;
        fail_at = fa;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && mask, "R2", "busy/mask after start", {busy, mask}, 2'b11);
        chk(!err, "R10", "err cleared by start", err, 0);
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            chk(mask == busy, "R2", "mask tracks busy", mask, busy);
            if (extra && $urandom_range(0, 299) == 0) start = 1'b1;
        end
        chk(!busy && !mask, "R7", "idle at done", {busy, mask}, 0);
        chk(first_ctrl == 8'h04, "R3", "setup control word", first_ctrl, 8'h04);
        chk(first_lo == 0 && first_hi == 0, "R3", "first address", {first_hi, first_lo}, 0);
        chk(last_ctrl == 8'h00, "R7", "closing control word", last_ctrl, 0);
        chk(viol_key == vk0, "R4", "unlock sequence violations", viol_key - vk0, 0);
        chk(viol_poll == vp0, "R5", "writes during busy", viol_poll - vp0, 0);
        chk(viol_order == vo0, "R6", "out-of-order writes", viol_order - vo0, 0);
        chk(viol_data == vd0, "R11", "write-back mismatches", viol_data - vd0, 0);
        chk(writes - w0 == exp_writes(inj, fa), extra ? "R8" : "R6", "write count",
            writes - w0, exp_writes(inj, fa));
        chk(err == inj, "R9", "error flag", err, inj);
        if (inj) chk(int'(err_addr) == fa, "R9", "failing address", err_addr, fa);
        mem_unchanged("R11");
        @(negedge clk);
        chk(!done, "R7", "done single cycle", done, 0);
        chk(err == inj, "R10", "error flag held", err, inj);
    endtask

    initial begin
        #(190000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !mask, "R1", "reset outputs", {busy, done, err, mask}, 0);
        repeat (5) @(negedge clk);
        chk(!reg_wr && !reg_rd, "R1", "bus quiet idle", {reg_wr, reg_rd}, 0);

        do_run(1'b0, 0, 1'b0);
        do_run(1'b1, $urandom_range(1, DEPTH - 2), 1'b0);
        repeat (4) @(negedge clk);
        chk(err, "R10", "error held while idle", err, 1);
        do_run(1'b0, 0, 1'b1);
        do_run(1'b1, 0, 1'b0);
        do_run(1'b1, DEPTH - 1, 1'b1);
        do_run(1'b0, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule